// File: doc/BRIEF.md
# GPIO Port with Alert Detection

A byte-wide general-purpose I/O port controlled through a small synchronous register bus. Each pin can be an input or an output, and an output can be push-pull or open-drain. The pads are modelled as three vectors: an output value, an output enable and a sampled input. A pin-ownership register sets, pin by pin, whether a pin belongs to the GPIO logic or is left to another function. Pins whose ownership bit is reserved always belong to the GPIO logic.

Each pin can watch its synchronised input for a rising edge, a falling edge, either edge, or an active-high or active-low level. Detected events are latched in a write-one-to-clear status register. A single-cycle alert pulse is raised when a status bit whose mask bit is set goes from 0 to 1. Software reads status and mask, services the bits set in both, and clears them by writing ones.

Register offsets on `bus_addr`: 0 ownership, 1 direction, 2 drive mode, 3 output data, 4 input data (read-only), 5 rise enable, 6 fall enable, 7 level polarity, 8 alert mask, 9 alert status. Any other offset reads as 0 and ignores writes.

Top module: `gpio_alert_port`

## Requirements
- R1: After reset every register reads 0, `pad_oe` and `pad_o` are 0 and `alert_o` is 0. Owned pins in the resulting active-low level mode set their status bit when their input is low.
- R2: An owned pin with direction bit 1 (output) and drive-mode bit 0 (push-pull) has `pad_oe`=1 and `pad_o` equal to its output-data bit. A pin with direction bit 0 (input) has `pad_oe`=0.
- R3: An owned output pin with drive-mode bit 1 (open-drain) has `pad_oe`=1 and `pad_o`=0 when its data bit is 0, and has `pad_oe`=0 when its data bit is 1. It never drives high.
- R4: A read strobe returns the addressed register on `bus_rdata` one cycle later. Writes to the read/write registers read back unchanged.
- R5: The input-data register returns `pad_i` after a two-flop synchroniser. Writes to it have no effect.
- R6: With rise enable 1 and fall enable 0 only rising edges set status. With fall only, only falling edges set status. With both, either edge sets status. A status bit is set on the third clock edge after the pad changes.
- R7: With both rise and fall enables 0 a pin is in level mode. Polarity bit 1 means active-high and 0 means active-low. Status is set on every cycle that the level holds, so a clear while the level is active is followed by a set one cycle later.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A clear in the same cycle as a new event wins.
- R9: `alert_o` is a one-cycle pulse. It rises only when a status bit whose mask bit is 1 goes from 0 to 1. A bit that stays set, or an unmasked bit, raises no alert.
- R10: Ownership bits outside `MUX_USABLE` read 0, ignore writes, and their pins are always owned. A pin that is not owned has `pad_oe`=0 and never sets status.
- R11: `pad_o` and `pad_oe` are registered and change on the clock edge after the register write that affects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data, valid one cycle after `bus_rd` |
| pad_i | input | N_PINS | Sampled pad levels |
| pad_o | output | N_PINS | Pad output value |
| pad_oe | output | N_PINS | Pad output enable |
| alert_o | output | 1 | Alert pulse on a new masked status bit |

## Verification
The assertions check the following on every cycle:
- An open-drain pin never drives high.
- The output enable needs both the direction bit and ownership.
- A status bit falls only after a write of 1 to it.
- An unowned pin never sets status.
- A rise-only pin sets status only after a rising edge.
- An active level always leads to a set status bit.
- Each alert pulse matches a new masked status bit.
- Read data arrives one cycle after the strobe.

Only the bench scenarios can show the following:
- The exact event latency through the synchroniser.
- That a held status bit raises no second alert.
- That reserved ownership bits read 0.
- That the input-data register ignores writes.
- The pad mapping across the full sweep of direction, drive mode, data and ownership.

// File: rtl/gap_pkg.sv
package gap_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_OWN  = 4'd0,
    A_DIR  = 4'd1,
    A_ODS  = 4'd2,
    A_DOUT = 4'd3,
    A_DIN  = 4'd4,
    A_RISE = 4'd5,
    A_FALL = 4'd6,
    A_LVL  = 4'd7,
    A_MASK = 4'd8,
    A_STAT = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gap_sync.sv
module gap_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] p
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      s      <= '0;
      p      <= '0;
    end else begin
      meta_q <= d;
      s      <= meta_q;
      p      <= s;
    end
  end
endmodule

// File: rtl/gap_alert.sv
module gap_alert #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] s,
  input  logic [W-1:0] p,
  input  logic [W-1:0] own,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat,
  output logic         alert
);
  logic [W-1:0] ev;
  logic [W-1:0] stat_nx;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic edge_mode;
    logic edge_hit;
    logic lvl_hit;
    assign edge_mode = rise[i] | fall[i];
    assign edge_hit  = (rise[i] & s[i] & ~p[i]) | (fall[i] & ~s[i] & p[i]);
    assign lvl_hit   = lvl[i] ? s[i] : ~s[i];
    assign ev[i]     = own[i] & (edge_mode ? edge_hit : lvl_hit);

    assert_rise_edge_R6: assert property (@(posedge clk) disable iff (rst)
      ($rose(stat[i]) && $past(rise[i] && !fall[i])) |-> $past(s[i] && !p[i]));

    assert_level_sets_R7: assert property (@(posedge clk) disable iff (rst)
      (own[i] && !rise[i] && !fall[i] && (lvl[i] == s[i]) && !clr[i]) |=> stat[i]);
  end

  // clear takes priority over a coincident event
  assign stat_nx = (stat | ev) & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat  <= '0;
      alert <= 1'b0;
    end else begin
      stat  <= stat_nx;
      alert <= |(stat_nx & ~stat & mask);
    end
  end

  assert_alert_new_set_R9: assert property (@(posedge clk) disable iff (rst)
    alert |-> |(stat & ~$past(stat) & $past(mask)));

  assert_stat_fall_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (($past(stat) & ~stat & ~$past(clr)) == '0));

  assert_unowned_no_set_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((stat & ~$past(stat) & ~$past(own)) == '0));
endmodule

// File: rtl/gap_pad.sv
module gap_pad #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] own,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ods,
  input  logic [W-1:0] dout,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= '0;
      pad_oe <= '0;
    end else begin
      pad_o  <= dout & ~ods;
      pad_oe <= own & dir & ~(ods & dout);
    end
  end

  assert_od_no_high_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(ods & dout)) == '0));

  assert_oe_needs_dir_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & ~$past(dir & own)) == '0));
endmodule

// File: rtl/gpio_alert_port.sv
module gpio_alert_port
  import gap_pkg::*;
#(
  parameter int                N_PINS     = 8,
  parameter logic [N_PINS-1:0] MUX_USABLE = N_PINS'(15)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe,
  output logic              alert_o
);
  localparam logic [N_PINS-1:0] ALWAYS_OWNED = ~MUX_USABLE;

  logic [N_PINS-1:0] own_r, dir_r, ods_r, dout_r, rise_r, fall_r, lvl_r, mask_r;
  logic [N_PINS-1:0] owned, s_in, p_in, stat, clr_vec, rd_val;

  assign owned   = own_r | ALWAYS_OWNED;
  assign clr_vec = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_r  <= '0;
      dir_r  <= '0;
      ods_r  <= '0;
      dout_r <= '0;
      rise_r <= '0;
      fall_r <= '0;
      lvl_r  <= '0;
      mask_r <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_OWN:  own_r  <= bus_wdata & MUX_USABLE;
        A_DIR:  dir_r  <= bus_wdata;
        A_ODS:  ods_r  <= bus_wdata;
        A_DOUT: dout_r <= bus_wdata;
        A_RISE: rise_r <= bus_wdata;
        A_FALL: fall_r <= bus_wdata;
        A_LVL:  lvl_r  <= bus_wdata;
        A_MASK: mask_r <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_OWN:   rd_val = own_r;
      A_DIR:   rd_val = dir_r;
      A_ODS:   rd_val = ods_r;
      A_DOUT:  rd_val = dout_r;
      A_DIN:   rd_val = s_in;
      A_RISE:  rd_val = rise_r;
      A_FALL:  rd_val = fall_r;
      A_LVL:   rd_val = lvl_r;
      A_MASK:  rd_val = mask_r;
      A_STAT:  rd_val = stat;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  gap_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_i), .s(s_in), .p(p_in)
  );

  gap_alert #(.W(N_PINS)) u_alert (
    .clk(clk), .rst(rst), .s(s_in), .p(p_in), .own(owned),
    .rise(rise_r), .fall(fall_r), .lvl(lvl_r), .mask(mask_r),
    .clr(clr_vec), .stat(stat), .alert(alert_o)
  );

  gap_pad #(.W(N_PINS)) u_pad (
    .clk(clk), .rst(rst), .own(owned), .dir(dir_r), .ods(ods_r),
    .dout(dout_r), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  assert_rdata_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_DIR) |=> (bus_rdata == $past(dir_r)));
endmodule

// File: tb/sim_gpio_alert_port.sv
module sim_gpio_alert_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] USABLE = 8'h0F;
  localparam logic [7:0] RISE_C = 8'hE5;
  localparam logic [7:0] FALL_C = 8'h06;
  localparam logic [7:0] LVL_C  = 8'h08;
  localparam logic [7:0] BASE   = 8'h12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, pad_i = '0, pad_o, pad_oe;
  logic alert_o;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_alert_port #(.N_PINS(8), .MUX_USABLE(USABLE)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe(pad_oe), .alert_o(alert_o)
  );

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    cyc();
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic count_alert(input int n, output int c);
    c = 0;
    repeat (n) begin cyc(); c += int'(alert_o); end
  endtask

  function automatic logic ev_model(int i, logic o, logic n);
    if (RISE_C[i] | FALL_C[i]) return (RISE_C[i] & n & ~o) | (FALL_C[i] & ~n & o);
    return LVL_C[i] ? n : ~n;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] own, dir, ods, dout, flip, e1, e2, e3;
    int c;
    cyc(3);
    rst = 1'b0;
    cyc(3);
    // R1: reset state; pins 4..7 always owned, active-low level, pad low
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_o", pad_o, 8'h00);
    chk("R1 alert", {7'd0, alert_o}, 8'h00);
    for (int a = 0; a < 9; a++) if (a != 4) rdchk("R1 reg", 4'(a), 8'h00);
    rdchk("R1 status from active-low level", 4'd9, 8'hF0);

    // R10: reserved ownership bits
    wr(4'd0, 8'hFF);
    rdchk("R10 reserved own bits", 4'd0, 8'h0F);

    // R4: read/write registers
    foreach (RISE_C[k]) ;
    for (int a = 1; a < 9; a++) begin
      if (a == 4) continue;
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pat;
        pat = 8'(8'hA5 ^ (p * 8'h3C));
        wr(4'(a), pat);
        rdchk("R4 readback", 4'(a), pat);
      end
      wr(4'(a), 8'h00);
    end

    // R5: input data through synchroniser, writes ignored
    pad_i = 8'h96;
    cyc(2);
    rdchk("R5 din", 4'd4, 8'h96);
    wr(4'd4, 8'h00);
    rdchk("R5 din write ignored", 4'd4, 8'h96);
    pad_i = 8'h00;

    // R2 R3 R10 R11: pad sweep
    for (int v = 0; v < 256; v++) begin
      own = 8'(v) & USABLE;
      dir = 8'(v) ^ 8'h5A;
      ods = {8'(v) >> 4} | {8'(v) << 4};
      dout = 8'(v * 3);
      wr(4'd0, 8'(v)); wr(4'd1, dir); wr(4'd2, ods); wr(4'd3, dout);
      cyc();
      own = own | ~USABLE;
      chk("R2 R3 R10 R11 pad_oe", pad_oe, own & dir & ~(ods & dout));
      chk("R2 R3 pad_o", pad_o, dout & ~ods);
    end
    // R11: one-edge latency of pad outputs
    wr(4'd0, 8'h0F); wr(4'd2, 8'h00); wr(4'd3, 8'hFF); wr(4'd1, 8'h00);
    cyc();
    chk("R11 settle", pad_oe, 8'h00);
    bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 8'hFF;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    chk("R11 before edge", pad_oe, 8'h00);
    @(negedge clk); @(posedge clk); @(negedge clk);
    chk("R11 after edge", pad_oe, 8'hFF);

    // R6 R7: per-pin event sweep
    wr(4'd5, RISE_C); wr(4'd6, FALL_C); wr(4'd7, LVL_C); wr(4'd8, 8'h00);
    pad_i = BASE;
    cyc(4);
    wr(4'd9, 8'hFF);
    cyc();
    rdchk("R8 clear all", 4'd9, 8'h00);
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = BASE[i];
      flip = BASE ^ (8'h01 << i);
      e1 = 8'(ev_model(i, b, ~b)) << i;
      e2 = (RISE_C[i] | FALL_C[i]) ? 8'h00 : e1;
      e3 = e2 | (8'(ev_model(i, ~b, b)) << i);
      pad_i = flip;
      cyc(3);
      rdchk("R6 R7 after change", 4'd9, e1);
      wr(4'd9, 8'hFF);
      cyc();
      rdchk("R7 R8 after clear", 4'd9, e2);
      pad_i = BASE;
      cyc(3);
      rdchk("R6 R7 after restore", 4'd9, e3);
      wr(4'd9, 8'hFF);
      cyc();
      rdchk("R8 cleared", 4'd9, 8'h00);
    end

    // R9: alert pulse behaviour
    wr(4'd8, 8'h01);
    pad_i = BASE | 8'h01;
    count_alert(6, c);
    chk("R9 one pulse on new bit", 8'(c), 8'd1);
    pad_i = BASE;
    cyc(3);
    pad_i = BASE | 8'h01;
    count_alert(6, c);
    chk("R9 held bit no new pulse", 8'(c), 8'd0);
    pad_i = BASE | 8'h21;
    count_alert(6, c);
    chk("R9 unmasked bit no pulse", 8'(c), 8'd0);
    rdchk("R9 status", 4'd9, 8'h21);
    // R8: selective clear and write of zero
    pad_i = BASE | 8'h25;
    cyc(4);
    rdchk("R6 both-edge pin2", 4'd9, 8'h25);
    wr(4'd9, 8'h04);
    rdchk("R8 clear one bit", 4'd9, 8'h21);
    wr(4'd9, 8'h00);
    rdchk("R8 write zero no effect", 4'd9, 8'h21);
    pad_i = BASE;
    cyc(4);
    wr(4'd9, 8'hFF);
    // R7 R9: level clear then re-set raises alert again
    wr(4'd8, 8'h08);
    pad_i = BASE | 8'h08;
    count_alert(6, c);
    chk("R7 R9 level first pulse", 8'(c), 8'd1);
    wr(4'd9, 8'h08);
    count_alert(4, c);
    chk("R7 R9 level re-set pulse", 8'(c), 8'd1);
    pad_i = BASE;
    cyc(4);
    wr(4'd9, 8'hFF);

    // R10: pin taken away generates no status
    wr(4'd0, 8'h0E);
    pad_i = BASE | 8'h01;
    cyc(4);
    rdchk("R10 unowned no status", 4'd9, 8'h00);
    chk("R10 unowned pad_oe", pad_oe & 8'h01, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule